// File: doc/BRIEF.md
# Protected clock select control register

This block holds the eight clock-selection control bits of a clock and power management unit. A bus port writes the register. Its contents drive the downstream clock multiplexers continuously and are also the read value, so a read can happen at any time. For each bit, the block decides whether a write is accepted. The decision depends on three things: a global write-protect input, the operating mode (normal or special), and a sticky lock. The lock engages on the first write to the separate watchdog control register.

Two of the bits select the watchdog clock source. The low one is cleared by hardware whenever the oscillator-good status is low. After such a clear, software gets a single chance to set it again, even when the watchdog lock is engaged. The high one is never touched by oscillator loss.

Top module: `clksel_ctrl`

## Requirements
- R1: After reset the register reads 0x80: bit 7 (PLL select) is 1 and bits 6..0 are 0.
- R2: While prot_i is 1, a write changes none of bits 7..1 in either mode. Bit 0 then changes only by the oscillator-loss clear of R7.
- R3: In special mode (special_i=1) with prot_i=0, all eight bits take the written value, whatever the state of the watchdog lock.
- R4: In normal mode (special_i=0) with prot_i=0, bits 7, 6, 3, 2 and 1 (mask 0xCE) take the written value at all times.
- R5: In normal mode, bits 5, 4 and 0 (mask 0x31) are writable only until the first watchdog strobe (wdog_wr_i=1) has been seen. A write in the same cycle as that strobe is still accepted. After that cycle these bits are locked.
- R6: When part of a write is rejected, the accepted bits update and the rejected bits keep their previous values. The write takes effect on the clock edge where wr_en_i is 1.
- R7: In any cycle with osc_ok_i=0, bit 0 is 0 after the edge. This clear takes priority over a write of 1 in the same cycle. Bit 4 is not affected by osc_ok_i.
- R8: When the clear of R7 turns a 1 in bit 0 into 0, bit 0 becomes writable once more in normal mode despite the lock. The first accepted write of 1 to bit 0 uses up that permission.
- R9: Reset releases the watchdog lock and the one-time permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| prot_i | input | 1 | Global write protect, 1 blocks all writes |
| special_i | input | 1 | 1 = special mode, 0 = normal mode |
| wdog_wr_i | input | 1 | Pulse marking a write to the watchdog control register |
| osc_ok_i | input | 1 | Oscillator-good status |
| reg_o | output | 8 | Register contents (read data and clock mux selects) |

## Verification
Two events can land on the same edge: a write of 1 to the low watchdog clock-source bit, and the hardware clear caused by oscillator loss. The bench provokes this in special mode by driving osc_ok_i low during a write of 0x31. The clear must win, so the result is 0x30, and the high source bit must survive the clear. That same edge must also arm the one-time permission, which is then judged by a later normal-mode write under the lock. A second overlap is the watchdog strobe arriving with a register write; the bench checks that this write still lands and the next one is blocked.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int unsigned REG_W     = 8;
  localparam logic [7:0]  RST_VAL   = 8'h80;
  // bits writable in normal mode at any time
  localparam logic [7:0]  FREE_MASK = 8'hCE;
  // bits frozen in normal mode once the watchdog is configured
  localparam logic [7:0]  LOCK_MASK = 8'h31;
  // watchdog clock-source bit cleared on oscillator loss
  localparam int unsigned OSC_BIT   = 0;
endpackage

// File: rtl/clksel_lock.sv
module clksel_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdog_wr_i,
  input  logic osc_ok_i,
  input  logic osc_bit_i,
  input  logic osc_set_ok_i,
  output logic lock_o,
  output logic rearm_o
);
  logic lock_q, rearm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b0;
      rearm_q <= 1'b0;
    end else begin
      if (wdog_wr_i) lock_q <= 1'b1;
      if (!osc_ok_i && osc_bit_i) rearm_q <= 1'b1;
      else if (osc_set_ok_i)      rearm_q <= 1'b0;
    end
  end

  assign lock_o  = lock_q;
  assign rearm_o = rearm_q;

  // R8
  rearm_use_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_set_ok_i && osc_ok_i) |=> !rearm_q);
  // R5
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
endmodule

// File: rtl/clksel_wmask.sv
module clksel_wmask
  import clksel_pkg::*;
#(
  parameter int unsigned W        = REG_W,
  parameter logic [W-1:0] FREE    = FREE_MASK,
  parameter logic [W-1:0] LOCKED  = LOCK_MASK,
  parameter int unsigned  OBIT    = OSC_BIT
) (
  input  logic         wr_en_i,
  input  logic         prot_i,
  input  logic         special_i,
  input  logic         lock_i,
  input  logic         rearm_i,
  output logic [W-1:0] we_o
);
  localparam logic [W-1:0] OBIT_MASK = W'(1) << OBIT;

  always_comb begin
    we_o = '0;
    if (wr_en_i && !prot_i) begin
      if (special_i) we_o = '1;
      else begin
        we_o = FREE;
        if (!lock_i) we_o = we_o | LOCKED;
        if (rearm_i) we_o = we_o | OBIT_MASK;
      end
    end
  end

  // R2
  prot_mask_chk: assert final (!(prot_i && (we_o != '0)));
endmodule

// File: rtl/clksel_bank.sv
module clksel_bank
  import clksel_pkg::*;
#(
  parameter int unsigned  W    = REG_W,
  parameter logic [W-1:0] RST  = RST_VAL,
  parameter int unsigned  OBIT = OSC_BIT
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         osc_ok_i,
  input  logic         prot_i,
  input  logic         wr_en_i,
  input  logic         special_i,
  input  logic         lock_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == OBIT) begin : g_osc
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        q[i] <= RST[i];
        else if (!osc_ok_i) q[i] <= 1'b0;
        else if (we_i[i])   q[i] <= wdata_i[i];
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      q[i] <= RST[i];
        else if (we_i[i]) q[i] <= wdata_i[i];
      end
    end
  end

  assign q_o = q;

  // R2
  prot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_i |=> $stable(q[7:1]));
  // R5
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !special_i && lock_i) |=> $stable(q[5:4]));
  // R7
  osc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_ok_i |=> !q[OBIT]);
  // R7
  osc_keep_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_ok_i && !wr_en_i) |=> $stable(q[4]));
  // R3
  special_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && special_i && !prot_i && osc_ok_i) |=> (q == $past(wdata_i)));
endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
  import clksel_pkg::*;
#(
  parameter int unsigned  W    = REG_W,
  parameter logic [W-1:0] RST  = RST_VAL,
  parameter int unsigned  OBIT = OSC_BIT
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  input  logic         prot_i,
  input  logic         special_i,
  input  logic         wdog_wr_i,
  input  logic         osc_ok_i,
  output logic [W-1:0] reg_o
);
  logic [W-1:0] we;
  logic         lock, rearm, osc_set_ok;

  assign osc_set_ok = we[OBIT] & wdata_i[OBIT] & osc_ok_i;

  clksel_lock u_lock (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wdog_wr_i    (wdog_wr_i),
    .osc_ok_i     (osc_ok_i),
    .osc_bit_i    (reg_o[OBIT]),
    .osc_set_ok_i (osc_set_ok),
    .lock_o       (lock),
    .rearm_o      (rearm)
  );

  clksel_wmask #(.W(W), .OBIT(OBIT)) u_wmask (
    .wr_en_i   (wr_en_i),
    .prot_i    (prot_i),
    .special_i (special_i),
    .lock_i    (lock),
    .rearm_i   (rearm),
    .we_o      (we)
  );

  clksel_bank #(.W(W), .RST(RST), .OBIT(OBIT)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we),
    .wdata_i   (wdata_i),
    .osc_ok_i  (osc_ok_i),
    .prot_i    (prot_i),
    .wr_en_i   (wr_en_i),
    .special_i (special_i),
    .lock_i    (lock),
    .q_o       (reg_o)
  );
endmodule

// File: tb/clksel_ctrl_test.sv
module clksel_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       prot = 1'b0;
  logic       special = 1'b0;
  logic       wdog_wr = 1'b0;
  logic       osc_ok = 1'b1;
  logic [7:0] rd;
  int         n_chk = 0;
  int         n_err = 0;

  always #10 clk = ~clk;

  clksel_ctrl uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wdata_i   (wdata),
    .prot_i    (prot),
    .special_i (special),
    .wdog_wr_i (wdog_wr),
    .osc_ok_i  (osc_ok),
    .reg_o     (rd)
  );

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (rd !== exp) begin
      n_err++;
      $display("FAIL %s: reg=%02h expected %02h", req, rd, exp);
    end
  endtask

  // one write cycle; result sampled at the following falling edge
  task automatic wr(input logic [7:0] d, input logic strobe_wd = 1'b0, input logic osc = 1'b1);
    @(negedge clk);
    wr_en = 1'b1; wdata = d; wdog_wr = strobe_wd; osc_ok = osc;
    @(negedge clk);
    wr_en = 1'b0; wdog_wr = 1'b0; osc_ok = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", 8'h80);
  endtask

  task automatic t_prot();
    prot = 1'b1; special = 1'b0;
    wr(8'h7F); check("R2", 8'h80);
    special = 1'b1;
    wr(8'h00); check("R2", 8'h80);
    prot = 1'b0;
  endtask

  task automatic t_special();
    special = 1'b1;
    wr(8'h3F); check("R3", 8'h3F);
    special = 1'b0;
  endtask

  task automatic t_unlocked();
    wr(8'hB1); check("R5", 8'hB1);
    wr(8'h80, 1'b1); check("R5", 8'h80);   // strobe same cycle: accepted
  endtask

  task automatic t_locked();
    wr(8'h7F); check("R4", 8'h4E);
    check("R6", 8'h4E);
    wr(8'h31); check("R6", 8'h00);
    wr(8'hFF); check("R5", 8'hCE);
  endtask

  task automatic t_special_over_lock();
    special = 1'b1;
    wr(8'h31); check("R3", 8'h31);
  endtask

  task automatic t_osc_conflict();
    special = 1'b1;
    wr(8'h31, 1'b0, 1'b0); check("R7", 8'h30);
    @(negedge clk); check("R7", 8'h30);
    special = 1'b0;
  endtask

  task automatic t_rearm();
    wr(8'h31); check("R8", 8'h31);
    wr(8'h30); check("R8", 8'h31);
    @(negedge clk); osc_ok = 1'b0;
    @(negedge clk); osc_ok = 1'b1;
    check("R7", 8'h30);
    wr(8'h00); check("R8", 8'h30);
    wr(8'h01); check("R8", 8'h31);
    wr(8'h00); check("R8", 8'h31);
  endtask

  task automatic t_reset_unlock();
    do_reset();
    check("R1", 8'h80);
    wr(8'h31); check("R9", 8'h31);
    wr(8'h30); check("R9", 8'h30);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_prot();
    t_special();
    t_unlocked();
    t_locked();
    t_special_over_lock();
    t_osc_conflict();
    t_rearm();
    t_reset_unlock();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_err++; n_chk++;
    $display("FAIL watchdog: reg=%02h expected end of run", rd);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule